// File: doc/BRIEF.md
# Two-Line Routed Interrupt Controller

This block collects up to 31 level-sensitive interrupt requests from peripherals and presents them to a processor on two lines: a low-priority line and a high-priority line. Software steers each source to exactly one of the two lines with a per-source route bit. It turns sources on and off through a pair of registers: one sets enable bits when written with ones, and the other clears them. A master enable bit gates both lines, so software can program every route and source enable before the processor sees any interrupt.

Each line has its own status register. This lets the handler for a line read only the sources that belong to it. The status registers show the live, enabled and asserted sources on their line. Each line is the OR of its status word, qualified by the master enable and registered for one clock. Access is through a simple single-cycle 32-bit register bus. Reads are combinational in the cycle of the request, and writes take effect at the next clock edge.

Top module: `dual_line_irq_ctrl`

## Requirements
- R1: After reset, and on every cycle while `rst_n` is low, all source enables, the master enable and all route bits are 0, and both `irq_lo_o` and `irq_hi_o` are 0.
- R2: A write to the set-enable register (byte address 0x0C) sets every source enable whose data bit (0..30) is 1 and sets the master enable when data bit 31 is 1. Zero bits leave their enables unchanged. A read of 0x0C or 0x10 returns the source enables in bits 0..30 and the master enable in bit 31.
- R3: A write to the clear-enable register (byte address 0x10) clears every enable whose data bit is 1, with bit 31 clearing the master enable, and leaves zero bits unchanged. Writing all ones clears every enable.
- R4: The route register (byte address 0x08) is written whole. Route bit i = 0 steers source i to the low line and 1 steers it to the high line. Bit 31 reads as 0.
- R5: The low status register (byte address 0x00) reads, in bit i, source i asserted AND enabled AND routed low. The high status register (byte address 0x04) reads the same for sources routed high. Bit 31 of both reads 0. The status registers are independent of the master enable.
- R6: No source is ever reported in both status registers at once.
- R7: Each output line equals the OR of its status word ANDed with the master enable, delayed by exactly one clock.
- R8: While the master enable is 0, both output lines are 0 one clock later, whatever the sources do.
- R9: An access with address bits [1:0] not zero, or to a word address above 0x10, writes nothing and reads 0. `bus_rdata` is 0 whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request |
| src_irq | input | 31 | Level interrupt request per source |
| irq_lo_o | output | 1 | Low-priority processor interrupt line |
| irq_hi_o | output | 1 | High-priority processor interrupt line |

## Verification
The assertions rely on the bus carrying at most one access per cycle. They also rely on `bus_sel`, `bus_wr`, `bus_addr`, `bus_wdata` and `src_irq` being known values at every clock edge, including the edges during and just after reset. The bench keeps to this: it drives every input to zero before releasing reset and changes inputs only on the falling clock edge. It issues accesses one at a time through tasks that drop `bus_sel` after one cycle. The source pattern changes only between accesses, so each status and output sample has a single cause.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned GLB_BIT = DATA_W - 1;

    // Word index of each register (byte address divided by 4).
    typedef enum logic [2:0] {
        RIDX_STAT_LO = 3'd0,
        RIDX_STAT_HI = 3'd1,
        RIDX_ROUTE   = 3'd2,
        RIDX_EN_SET  = 3'd3,
        RIDX_EN_CLR  = 3'd4
    } reg_idx_e;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic               route_stb,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] src_en,
    output logic               glb_en,
    output logic [NUM_SRC-1:0] route_hi
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               glb;
        logic [NUM_SRC-1:0] route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (set_stb) begin
            cfg_d.en  = cfg_q.en | wdata[NUM_SRC-1:0];
            cfg_d.glb = cfg_q.glb | wdata[GLB_BIT];
        end
        if (clr_stb) begin
            cfg_d.en  = cfg_q.en & ~wdata[NUM_SRC-1:0];
            cfg_d.glb = cfg_q.glb & ~wdata[GLB_BIT];
        end
        if (route_stb) begin
            cfg_d.route = wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign src_en   = cfg_q.en;
    assign glb_en   = cfg_q.glb;
    assign route_hi = cfg_q.route;

    // R1: configuration held clear during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_cfg_reset_R1: assert (cfg_q == '0)
                else $error("config not clear in reset");
        end
    end

    // R2: ones written to the set register end up set
    assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> (((cfg_q.en & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]))
                     && (cfg_q.glb || !$past(wdata[GLB_BIT]))));

    // R3: ones written to the clear register end up clear
    assert_clr_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (((cfg_q.en & $past(wdata[NUM_SRC-1:0])) == '0)
                     && (!cfg_q.glb || !$past(wdata[GLB_BIT]))));

    // R4: route register follows the written word
    assert_route_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        route_stb |=> (cfg_q.route == $past(wdata[NUM_SRC-1:0])));

endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
    parameter int unsigned NUM_SRC = 31
) (
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] route_hi,
    output logic [NUM_SRC-1:0] stat_lo,
    output logic [NUM_SRC-1:0] stat_hi
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic live;
        assign live       = src_irq[i] & src_en[i];
        assign stat_lo[i] = live & ~route_hi[i];
        assign stat_hi[i] = live &  route_hi[i];
    end

endmodule

// File: rtl/irqc_out.sv
module irqc_out #(
    parameter int unsigned NUM_SRC = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] stat_lo,
    input  logic [NUM_SRC-1:0] stat_hi,
    output logic               irq_lo,
    output logic               irq_hi
);

    typedef struct packed {
        logic lo;
        logic hi;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d    = line_q;
        line_d.lo = glb_en & (|stat_lo);
        line_d.hi = glb_en & (|stat_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign irq_lo = line_q.lo;
    assign irq_hi = line_q.hi;

    // R1: lines quiet during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_lines_reset_R1: assert (!line_q.lo && !line_q.hi)
                else $error("line raised in reset");
        end
    end

endmodule

// File: rtl/dual_line_irq_ctrl.sv
module dual_line_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 31,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_irq,
    output logic               irq_lo_o,
    output logic               irq_hi_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [NUM_SRC-1:0] src_en, route_hi, stat_lo, stat_hi;
    logic               glb_en;
    logic               aligned;
    logic [IDX_W-1:0]   idx;
    logic               set_stb, clr_stb, route_stb;

    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign idx       = bus_addr[ADDR_W-1:2];
    assign set_stb   = bus_sel & bus_wr & aligned & (idx == IDX_W'(RIDX_EN_SET));
    assign clr_stb   = bus_sel & bus_wr & aligned & (idx == IDX_W'(RIDX_EN_CLR));
    assign route_stb = bus_sel & bus_wr & aligned & (idx == IDX_W'(RIDX_ROUTE));

    irqc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb   (set_stb),
        .clr_stb   (clr_stb),
        .route_stb (route_stb),
        .wdata     (bus_wdata),
        .src_en    (src_en),
        .glb_en    (glb_en),
        .route_hi  (route_hi)
    );

    irqc_route #(.NUM_SRC(NUM_SRC)) u_route (
        .src_irq  (src_irq),
        .src_en   (src_en),
        .route_hi (route_hi),
        .stat_lo  (stat_lo),
        .stat_hi  (stat_hi)
    );

    irqc_out #(.NUM_SRC(NUM_SRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_en  (glb_en),
        .stat_lo (stat_lo),
        .stat_hi (stat_hi),
        .irq_lo  (irq_lo_o),
        .irq_hi  (irq_hi_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && aligned) begin
            case (idx)
                IDX_W'(RIDX_STAT_LO): bus_rdata[NUM_SRC-1:0] = stat_lo;
                IDX_W'(RIDX_STAT_HI): bus_rdata[NUM_SRC-1:0] = stat_hi;
                IDX_W'(RIDX_ROUTE):   bus_rdata[NUM_SRC-1:0] = route_hi;
                IDX_W'(RIDX_EN_SET),
                IDX_W'(RIDX_EN_CLR): begin
                    bus_rdata[NUM_SRC-1:0] = src_en;
                    bus_rdata[GLB_BIT]     = glb_en;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R6: the two status words never share a source
    assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo & stat_hi) == '0);

    // R7: each line tracks its gated status one clock later
    assert_line_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_lo_o == $past(glb_en && (stat_lo != '0)))
               && (irq_hi_o == $past(glb_en && (stat_hi != '0)))));

    // R8: master enable off silences both lines
    assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (!irq_lo_o && !irq_hi_o));

    // R9: nothing is returned without a read request
    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> (bus_rdata == '0));

endmodule

// File: tb/dual_line_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dual_line_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [30:0] src_irq = '0;
    logic        irq_lo_o, irq_hi_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dual_line_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_irq   (src_irq),
        .irq_lo_o  (irq_lo_o),
        .irq_hi_o  (irq_hi_o)
    );

    localparam logic [4:0] A_SLO = 5'h00, A_SHI = 5'h04, A_RTE = 5'h08,
                           A_SET = 5'h0C, A_CLR = 5'h10, A_BAD = 5'h1C;

    typedef struct packed {
        logic        wr;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [30:0] src;
        logic [4:0]  raddr;
        logic [31:0] exp;
        logic        lo;
        logic        hi;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, A_SET, 32'h8000_000F, 31'h0000_0005, A_SET, 32'h8000_000F, 1'b1, 1'b0},
        '{1'b1, A_RTE, 32'h0000_0004, 31'h0000_0005, A_SHI, 32'h0000_0004, 1'b1, 1'b1},
        '{1'b0, A_SLO, 32'h0000_0000, 31'h0000_0005, A_SLO, 32'h0000_0001, 1'b1, 1'b1},
        '{1'b1, A_CLR, 32'h0000_0004, 31'h0000_0004, A_SET, 32'h8000_000B, 1'b0, 1'b0},
        '{1'b1, A_SET, 32'h0000_0100, 31'h7FFF_FFFF, A_SLO, 32'h0000_010B, 1'b1, 1'b0},
        '{1'b1, A_CLR, 32'h8000_0000, 31'h7FFF_FFFF, A_CLR, 32'h0000_010B, 1'b0, 1'b0},
        '{1'b1, A_SET, 32'h8000_0000, 31'h7FFF_FFFF, A_SHI, 32'h0000_0000, 1'b1, 1'b0},
        '{1'b1, A_RTE, 32'hFFFF_FFFF, 31'h7FFF_FFFF, A_RTE, 32'h7FFF_FFFF, 1'b0, 1'b1},
        '{1'b1, A_BAD, 32'hFFFF_FFFF, 31'h7FFF_FFFF, A_BAD, 32'h0000_0000, 1'b0, 1'b1},
        '{1'b1, A_CLR, 32'hFFFF_FFFF, 31'h7FFF_FFFF, A_SET, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_addr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, with every source asserted
        src_irq = '1;
        @(negedge clk);
        bus_read(A_SET, rd); check("R1 enables after reset", rd, 32'h0);
        bus_read(A_RTE, rd); check("R1 route after reset", rd, 32'h0);
        bus_read(A_SLO, rd); check("R5 low status with nothing enabled", rd, 32'h0);
        check("R1 lines after reset", {30'h0, irq_lo_o, irq_hi_o}, 32'h0);
        src_irq = '0;

        // Vector walk: R2 R3 R4 R5 R7 R8 R9
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            src_irq = VEC[k].src;
            if (VEC[k].wr) bus_write(VEC[k].waddr, VEC[k].wdata);
            else           @(negedge clk);
            @(negedge clk);
            bus_read(VEC[k].raddr, rd);
            check($sformatf("R2/R3/R4/R5/R9 vector %0d read", k), rd, VEC[k].exp);
            check($sformatf("R7/R8 vector %0d low line", k), {31'h0, irq_lo_o}, {31'h0, VEC[k].lo});
            check($sformatf("R7/R8 vector %0d high line", k), {31'h0, irq_hi_o}, {31'h0, VEC[k].hi});
        end

        // R7: exactly one clock from status to line
        bus_write(A_RTE, 32'h0);
        src_irq = 31'h1;
        bus_write(A_SET, 32'h8000_0001);
        check("R7 line not yet raised", {31'h0, irq_lo_o}, 32'h0);
        @(negedge clk);
        check("R7 line raised one clock later", {31'h0, irq_lo_o}, 32'h1);

        // R3: zeros written to clear register change nothing
        bus_write(A_CLR, 32'h0);
        bus_read(A_CLR, rd); check("R3 zero clear no effect", rd, 32'h8000_0001);

        // R8: master off, status still visible, line low
        bus_write(A_CLR, 32'h8000_0000);
        @(negedge clk);
        bus_read(A_SLO, rd); check("R8 status independent of master", rd, 32'h1);
        check("R8 line low with master off", {31'h0, irq_lo_o}, 32'h0);

        // R9: misaligned write and read ignored
        bus_write(5'h0D, 32'h0000_0002);
        bus_read(A_SET, rd); check("R9 misaligned write ignored", rd, 32'h0000_0001);
        bus_read(5'h01, rd); check("R9 misaligned read zero", rd, 32'h0);
        #1;
        check("R9 idle rdata zero", bus_rdata, 32'h0);

        // R1: reset in mid run clears state
        bus_write(A_SET, 32'h8000_0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 lines in reset", {30'h0, irq_lo_o, irq_hi_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(A_SET, rd); check("R1 enables after second reset", rd, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule